// File: doc/BRIEF.md
# Write-Only Control Register Slave

This block is a two-wire serial slave that only accepts writes. Each transaction carries a 7-bit device address with the write direction bit, then an 8-bit sub-address, then one data byte. The data byte lands in one of ten 8-bit control registers: horizontal position, vertical position, encoder control, input control, three bytes of the colour subcarrier increment, two bytes of the PLL divider and a setup register.

Every register has an override flag. The flag is set by the first accepted write and stays set until reset. Downstream logic uses the flag to let the written value take precedence over pin straps and sync-coded commands. The three subcarrier bytes fall back to a built-in default for each TV standard until they are written. SCL and SDA are sampled by a system clock that runs at least 16 times faster than SCL. The slave answers by pulling SDA low through `sda_oe_o`.

Top module: `ctl_wr_slave`

## Requirements
- R1: After reset, every register reads 0, every override flag is 0 and `sda_oe_o` is 0. `fsc_o` shows 21F07Bh while `pal_mode`=0 and 2A098Ah while `pal_mode`=1.
- R2: The device address is 7'b100010 followed by `addr_sel`, so 44h or 45h. An address byte that matches and has R/W=0 (the bit after the 7 address bits) is acknowledged: `sda_oe_o` is high during the ninth SCL pulse.
- R3: A byte with R/W=1, any other address, or the general call address 00h is not acknowledged, and nothing in that transaction changes a register.
- R4: Sub-addresses map to override bit and output as follows. 06h to bit 0 (`hpos_o`), 07h to bit 1 (`vpos_o`), 08h to bit 2 (`enc_ctl_o`), 09h to bit 3 (`in_ctl_o`). 03h, 04h and 05h go to bits 4, 5 and 6, which are `fsc_o` bits 23:16, 15:8 and 7:0. 0Bh to bit 7 (`pll_hi_o`), 0Ch to bit 8 (`pll_lo_o`), 0Dh to bit 9 (`setup_o`).
- R5: After an acknowledged address, the sub-address byte and the data byte are each acknowledged. When the data byte completes, the decoded register takes the data and its override bit becomes 1.
- R6: A write to any other sub-address is acknowledged in every byte but changes no register and no override bit.
- R7: A Stop or a repeated Start before the data byte is complete aborts the write, and no register changes. A complete transaction after a repeated Start is accepted normally.
- R8: An override bit, once set, stays 1 through later writes and is cleared only by reset. A rewrite replaces the value.
- R9: While `en_n` is 1, no byte is acknowledged and no register changes.
- R10: Bytes sent after the data byte in the same transaction are not acknowledged and do not change any register.
- R11: Each `fsc_o` byte whose override bit is 0 follows the default for the current `pal_mode`. A written byte keeps its value when `pal_mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low interface enable |
| addr_sel | input | 1 | Device address LSB select |
| pal_mode | input | 1 | Selects the PAL subcarrier default (1) or the NTSC default (0) |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| hpos_o | output | 8 | Horizontal position, two's complement, steps of 2 pixels |
| vpos_o | output | 8 | Vertical position, two's complement, steps of 1 line |
| enc_ctl_o | output | 8 | Encoder control byte |
| in_ctl_o | output | 8 | Input control byte |
| fsc_o | output | 24 | Subcarrier increment, written bytes or defaults |
| pll_hi_o | output | 8 | PLL divider upper control byte |
| pll_lo_o | output | 8 | PLL divider lower byte |
| setup_o | output | 8 | Setup byte |
| ovr_o | output | 10 | Sticky override flags, bit order per R4 |

## Verification
The hardest case to reach is an abort in the middle of the data byte. By then the address and sub-address have been accepted and only the final byte is missing. The bench builds this case bit by bit: it sends four data bits, then either drives a Stop or raises SDA and drops it again while SCL is high to form a repeated Start. A behavioural model of the register file and flags is compared against the outputs on every idle clock. The model changes only when a transaction runs to completion, so a partial commit shows up as a mismatch.

// File: rtl/ctlwr_pkg.sv
package ctlwr_pkg;
  localparam int NREG  = 10;
  localparam int DW    = 8;
  localparam int SLOTW = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK, PH_IGN} phase_t;

  typedef struct packed {
    logic             hit;
    logic [SLOTW-1:0] slot;
  } slot_t;

  // sub-address to register slot; slot order equals override bit order
  function automatic slot_t sub_decode(input logic [DW-1:0] sub);
    slot_t s;
    s.hit  = 1'b1;
    s.slot = '0;
    case (sub)
      8'h06: s.slot = 4'd0;
      8'h07: s.slot = 4'd1;
      8'h08: s.slot = 4'd2;
      8'h09: s.slot = 4'd3;
      8'h03: s.slot = 4'd4;
      8'h04: s.slot = 4'd5;
      8'h05: s.slot = 4'd6;
      8'h0B: s.slot = 4'd7;
      8'h0C: s.slot = 4'd8;
      8'h0D: s.slot = 4'd9;
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ctlwr_line_sync.sv
module ctlwr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_p,
  output logic stop_p
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_q, sda_q;
  logic scl_s, scl_d, sda_s, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign scl_d    = scl_q[STAGES];
  assign sda_s    = sda_q[STAGES-1];
  assign sda_d    = sda_q[STAGES];
  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ctlwr_byte_fsm.sv
module ctlwr_byte_fsm
  import ctlwr_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [AW-1:0] dev_addr,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_p,
  input  logic          stop_p,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [DW-1:0] wr_sub,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  phase_t        phase;
  logic [1:0]    idx;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      bitcnt  <= '0;
      sh      <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_sub  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (en_n) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (start_p) begin
        phase  <= PH_RX;
        idx    <= '0;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise) begin
              sh     <= {sh[DW-2:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              case (idx)
                2'd0: begin
                  if (sh[DW-1:1] == dev_addr && !sh[0]) begin
                    phase  <= PH_ACK;
                    sda_oe <= 1'b1;
                  end else begin
                    phase <= PH_IGN;
                  end
                end
                2'd1: begin
                  wr_sub <= sh;
                  phase  <= PH_ACK;
                  sda_oe <= 1'b1;
                end
                default: begin
                  wr_data <= sh;
                  wr_stb  <= 1'b1;
                  phase   <= PH_ACK;
                  sda_oe  <= 1'b1;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (idx == 2'd2) begin
                phase <= PH_IGN;
              end else begin
                idx   <= idx + 1'b1;
                phase <= PH_RX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctlwr_reg_bank.sv
module ctlwr_reg_bank
  import ctlwr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_sub,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] regs [NREG],
  output logic [NREG-1:0] ovr
);
  slot_t dec;
  assign dec = sub_decode(wr_sub);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
        ovr[g]  <= 1'b0;
      end else if (wr_stb && dec.hit && dec.slot == SLOTW'(g)) begin
        regs[g] <= wr_data;
        ovr[g]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_wr_slave.sv
module ctl_wr_slave
  import ctlwr_pkg::*;
#(
  parameter logic [5:0]  DEV_BASE = 6'b100010,
  parameter logic [23:0] FSC_NTSC = 24'h21F07B,
  parameter logic [23:0] FSC_PAL  = 24'h2A098A,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_n,
  input  logic        addr_sel,
  input  logic        pal_mode,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [7:0]  hpos_o,
  output logic [7:0]  vpos_o,
  output logic [7:0]  enc_ctl_o,
  output logic [7:0]  in_ctl_o,
  output logic [23:0] fsc_o,
  output logic [7:0]  pll_hi_o,
  output logic [7:0]  pll_lo_o,
  output logic [7:0]  setup_o,
  output logic [9:0]  ovr_o
);
  localparam int FSC_SLOT0 = 4;
  localparam int FSC_BYTES = 3;

  logic scl_rise, scl_fall, sda_lvl, start_p, stop_p;
  logic wr_stb;
  logic [DW-1:0] wr_sub, wr_data;
  logic [DW-1:0] regs [NREG];
  logic [NREG-1:0] ovr;
  logic [23:0] fsc_dflt;

  ctlwr_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_p(start_p), .stop_p(stop_p)
  );

  ctlwr_byte_fsm #(.AW(7)) i_fsm (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dev_addr({DEV_BASE, addr_sel}),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_p(start_p), .stop_p(stop_p), .sda_oe(sda_oe_o),
    .wr_stb(wr_stb), .wr_sub(wr_sub), .wr_data(wr_data)
  );

  ctlwr_reg_bank i_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sub(wr_sub),
    .wr_data(wr_data), .regs(regs), .ovr(ovr)
  );

  assign fsc_dflt = pal_mode ? FSC_PAL : FSC_NTSC;

  for (genvar b = 0; b < FSC_BYTES; b++) begin : g_fsc
    assign fsc_o[23-8*b -: 8] = ovr[FSC_SLOT0+b] ? regs[FSC_SLOT0+b]
                                                 : fsc_dflt[23-8*b -: 8];
  end

  assign hpos_o    = regs[0];
  assign vpos_o    = regs[1];
  assign enc_ctl_o = regs[2];
  assign in_ctl_o  = regs[3];
  assign pll_hi_o  = regs[7];
  assign pll_lo_o  = regs[8];
  assign setup_o   = regs[9];
  assign ovr_o     = ovr;
endmodule

// File: rtl/ctl_wr_slave_chk.sv
module ctl_wr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [7:0] hpos_o,
  input logic [9:0] ovr_o
);
  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !sda_oe_o);

  // R8
  sticky_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovr_o & $past(ovr_o)) == $past(ovr_o)));

  // R5
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ovr_o ^ $past(ovr_o)) <= 1));

  // R4
  hpos_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hpos_o) |-> ovr_o[0]);

  // R2
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind ctl_wr_slave ctl_wr_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .scl_i(scl_i),
  .sda_oe_o(sda_oe_o), .hpos_o(hpos_o), .ovr_o(ovr_o)
);

// File: tb/test_ctl_wr_slave.sv
module test_ctl_wr_slave;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b0;
  logic addr_sel = 1'b0;
  logic pal_mode = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_w;
  logic sda_oe_o;
  logic [7:0] hpos_o, vpos_o, enc_ctl_o, in_ctl_o, pll_hi_o, pll_lo_o, setup_o;
  logic [23:0] fsc_o;
  logic [9:0] ovr_o;

  int total = 0;
  int bad = 0;
  bit busy = 1'b1;
  string cur_req = "R1";

  int exp_r [10];
  bit exp_o [10];

  always #2 clk = ~clk;
  assign sda_w = sda_m & ~sda_oe_o;

  ctl_wr_slave i_ctl_wr_slave (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .addr_sel(addr_sel),
    .pal_mode(pal_mode), .scl_i(scl), .sda_i(sda_w), .sda_oe_o(sda_oe_o),
    .hpos_o(hpos_o), .vpos_o(vpos_o), .enc_ctl_o(enc_ctl_o),
    .in_ctl_o(in_ctl_o), .fsc_o(fsc_o), .pll_hi_o(pll_hi_o),
    .pll_lo_o(pll_lo_o), .setup_o(setup_o), .ovr_o(ovr_o)
  );

  function automatic int slot_of(input int sub);
    case (sub)
      'h06: return 0;  'h07: return 1;  'h08: return 2;  'h09: return 3;
      'h03: return 4;  'h04: return 5;  'h05: return 6;  'h0B: return 7;
      'h0C: return 8;  'h0D: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic logic [23:0] exp_fsc();
    logic [23:0] d;
    d = pal_mode ? 24'h2A098A : 24'h21F07B;
    for (int b = 0; b < 3; b++)
      if (exp_o[4+b]) d[23-8*b -: 8] = exp_r[4+b][7:0];
    return d;
  endfunction

  function automatic logic [9:0] exp_ovr();
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = exp_o[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 10; i++) begin
      exp_r[i] = 0;
      exp_o[i] = 1'b0;
    end
  endtask

  task automatic model_write(input int sub, input int data);
    int s;
    s = slot_of(sub);
    if (s >= 0) begin
      exp_r[s] = data;
      exp_o[s] = 1'b1;
    end
  endtask

  task automatic check(input string req, input string what, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // per-clock comparison against the model while the bus is idle
  always @(negedge clk) begin
    if (!busy && rst_n) begin
      check(cur_req, "hpos", hpos_o, exp_r[0]);
      check(cur_req, "vpos", vpos_o, exp_r[1]);
      check(cur_req, "enc", enc_ctl_o, exp_r[2]);
      check(cur_req, "inctl", in_ctl_o, exp_r[3]);
      check(cur_req, "fsc", fsc_o, exp_fsc());
      check(cur_req, "pllhi", pll_hi_o, exp_r[7]);
      check(cur_req, "pllo", pll_lo_o, exp_r[8]);
      check(cur_req, "setup", setup_o, exp_r[9]);
      check(cur_req, "ovr", ovr_o, exp_ovr());
      check(cur_req, "sda_oe idle", sda_oe_o, 0);
    end
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start();
    sda_m = 1'b1; scl = 1'b1; wait_h(H);
    sda_m = 1'b0; wait_h(H);
    scl = 1'b0; wait_h(H / 2);
  endtask

  task automatic t_rstart();
    sda_m = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(H);
    sda_m = 1'b0; wait_h(H);
    scl = 1'b0; wait_h(H / 2);
  endtask

  task automatic t_stop();
    sda_m = 1'b0; wait_h(H);
    scl = 1'b1; wait_h(H);
    sda_m = 1'b1; wait_h(H);
  endtask

  task automatic t_bit(input logic b);
    sda_m = b; wait_h(H);
    scl = 1'b1; wait_h(H);
    scl = 1'b0;
  endtask

  task automatic t_byte(input logic [7:0] b, input bit exp_ack, input string req, input string what);
    for (int i = 7; i >= 0; i--) t_bit(b[i]);
    sda_m = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(H / 2);
    check(req, what, sda_oe_o, exp_ack);
    wait_h(H / 2);
    scl = 1'b0;
  endtask

  task automatic xfer(input logic [6:0] dev, input logic rw, input int sub, input int data, input string req);
    bit ack;
    busy = 1'b1;
    cur_req = req;
    ack = !en_n && dev == {6'b100010, addr_sel} && !rw;
    t_start();
    t_byte({dev, rw}, ack, req, "addr ack");
    t_byte(sub[7:0], ack, req, "sub ack");
    t_byte(data[7:0], ack, req, "data ack");
    t_stop();
    if (ack) model_write(sub, data);
    busy = 1'b0;
    wait_h(8);
  endtask

  task automatic do_reset();
    busy = 1'b1;
    rst_n = 1'b0;
    scl = 1'b1; sda_m = 1'b1;
    wait_h(6);
    rst_n = 1'b1;
    model_reset();
    wait_h(4);
    busy = 1'b0;
    wait_h(4);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state with both standard defaults
    cur_req = "R1";
    check("R1", "fsc ntsc", fsc_o, 24'h21F07B);
    check("R1", "ovr", ovr_o, 0);
    pal_mode = 1'b1; wait_h(4);
    check("R1", "fsc pal", fsc_o, 24'h2A098A);
    pal_mode = 1'b0; wait_h(4);

    // R2 address 44h acknowledged; R5 commit
    xfer(7'h44, 1'b0, 'h06, 'hA5, "R2");
    xfer(7'h44, 1'b0, 'h07, 'hF4, "R5");
    // R2 addr_sel picks 45h, and 44h is then foreign
    addr_sel = 1'b1; wait_h(4);
    xfer(7'h45, 1'b0, 'h08, 'h3C, "R2");
    xfer(7'h44, 1'b0, 'h09, 'h11, "R2");
    addr_sel = 1'b0; wait_h(4);

    // R3 read bit, general call, wrong address
    xfer(7'h44, 1'b1, 'h09, 'h22, "R3");
    xfer(7'h00, 1'b0, 'h09, 'h33, "R3");
    xfer(7'h50, 1'b0, 'h06, 'h44, "R3");

    // R11 one subcarrier byte, then flip the standard
    xfer(7'h44, 1'b0, 'h04, 'h5A, "R11");
    pal_mode = 1'b1; wait_h(6);
    check("R11", "fsc mixed pal", fsc_o, 24'h2A5A8A);
    pal_mode = 1'b0; wait_h(6);
    check("R11", "fsc mixed ntsc", fsc_o, 24'h215A7B);

    // R6 undefined sub-addresses
    xfer(7'h44, 1'b0, 'h0A, 'h77, "R6");
    xfer(7'h44, 1'b0, 'h00, 'h78, "R6");
    xfer(7'h44, 1'b0, 'hFF, 'h79, "R6");

    // R4 every defined sub-address
    xfer(7'h44, 1'b0, 'h03, 'h12, "R4");
    xfer(7'h44, 1'b0, 'h05, 'h34, "R4");
    xfer(7'h44, 1'b0, 'h09, 'h56, "R4");
    xfer(7'h44, 1'b0, 'h0B, 'h78, "R4");
    xfer(7'h44, 1'b0, 'h0C, 'h9A, "R4");
    xfer(7'h44, 1'b0, 'h0D, 'hBC, "R4");
    check("R4", "fsc all written", fsc_o, 24'h125A34);

    // R7 Stop in mid data byte
    busy = 1'b1; cur_req = "R7";
    t_start();
    t_byte(8'h88, 1'b1, "R7", "addr ack");
    t_byte(8'h08, 1'b1, "R7", "sub ack");
    t_bit(1'b1); t_bit(1'b1); t_bit(1'b0); t_bit(1'b1);
    t_stop();
    busy = 1'b0; wait_h(8);
    check("R7", "enc after stop abort", enc_ctl_o, 8'h3C);

    // R7 repeated Start in mid data byte, then a full write
    busy = 1'b1;
    t_start();
    t_byte(8'h88, 1'b1, "R7", "addr ack");
    t_byte(8'h06, 1'b1, "R7", "sub ack");
    t_bit(1'b0); t_bit(1'b0); t_bit(1'b0); t_bit(1'b0);
    t_rstart();
    t_byte(8'h88, 1'b1, "R7", "addr ack after rstart");
    t_byte(8'h07, 1'b1, "R7", "sub ack after rstart");
    t_byte(8'h2E, 1'b1, "R7", "data ack after rstart");
    t_stop();
    model_write('h07, 'h2E);
    busy = 1'b0; wait_h(8);
    check("R7", "hpos kept", hpos_o, 8'hA5);

    // R10 extra byte after data
    busy = 1'b1; cur_req = "R10";
    t_start();
    t_byte(8'h88, 1'b1, "R10", "addr ack");
    t_byte(8'h0D, 1'b1, "R10", "sub ack");
    t_byte(8'h01, 1'b1, "R10", "data ack");
    t_byte(8'hFE, 1'b0, "R10", "extra byte no ack");
    t_stop();
    model_write('h0D, 'h01);
    busy = 1'b0; wait_h(8);
    check("R10", "setup first byte", setup_o, 8'h01);

    // R9 interface disabled
    en_n = 1'b1; wait_h(4);
    xfer(7'h44, 1'b0, 'h06, 'h00, "R9");
    en_n = 1'b0; wait_h(4);

    // R8 rewrite keeps flag, reset clears it
    xfer(7'h44, 1'b0, 'h06, 'h00, "R8");
    check("R8", "hpos ovr stays", ovr_o[0], 1);
    do_reset();
    cur_req = "R8";
    check("R8", "ovr cleared", ovr_o, 0);
    check("R8", "fsc default back", fsc_o, 24'h21F07B);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule